// File: doc/BRIEF.md
# Gain-Stabilized Coupled Quadrature Oscillator

This block generates a complex sinusoid as two signed fixed-point streams, an in-phase stream and a quadrature stream. On every enabled clock it rotates the stored complex sample by a step angle. The step angle is given as its cosine and sine on two input words, and it can be changed at any time. A cheap amplitude correction then scales the rotated sample. The correction is 3/2 minus the instantaneous power of the rotated sample. It needs no divider and no square root, and it pulls the sample power toward 1/2, which is a peak amplitude of about 0.7071. Without it, coefficient quantization would make a plain rotation recursion grow or decay over time.

All samples, coefficients and the gain use signed Q2.14 words (16 bits, 1.0 = 16384). Every product or sum of products is rounded back to Q2.14 and clamped to the word range. A start pulse or reset reloads the state with 1.0 + j0. The caller supplies the step-angle coefficients: 16384·cos(2π·f/fs) and 16384·sin(2π·f/fs). Tuning runs from near zero up to near half the sample rate.

Top module: `quad_osc_agc`

## Requirements
- R1: While `rst` is high and on the cycle after it, `out_i` = 16384, `out_q` = 0 and `out_valid` = 0.
- R2: `start` high at a clock edge reloads the state to `out_i` = 16384, `out_q` = 0 and clears `out_valid`. It has priority over `en`.
- R3: An edge with `en` low (and no `start`) leaves `out_i`/`out_q` unchanged and drives `out_valid` low. The values on `cos_in`/`sin_in` at that edge have no effect on any later output.
- R4: After every edge with `en` high and no `start`, `out_valid` is high for that following cycle.
- R5: An enabled step first rotates the previous output (i, q) into i' = rs(i·c − q·s) and q' = rs(q·c + i·s). Here c and s are `cos_in` and `sin_in` sampled at that same edge.
- R6: The rotated pair is then scaled by g = 24576 − p, with p = rs(i'² + q'²). The step outputs are rs(g·i') and rs(g·q').
- R7: rs(x) is round-to-nearest from Q4.28 to Q2.14, with ties toward +infinity: floor((x + 8192) / 16384). The result is clamped to [−32768, 32767].
- R8: When the rotated power exceeds the word range, p clamps to 32767 and the gain becomes −8191. Example: c = s = 32767 applied to the state 1.0 + j0.
- R9: With a fixed step angle and the state reloaded to 1.0, the power (i² + q²)/16384 stays within 100 LSB of 8192 from step 200 to step 4000 onward.
- R10: For any tuning from near zero to near half the sample rate, once the amplitude has settled, the phase advance between successive outputs matches atan2(s, c) within 0.003 rad.
- R11: New coefficients act on the very enabled step that samples them. Afterwards the power settles back within the R9 tolerance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Step enable, one rotation per enabled edge |
| start | input | 1 | Reload state to 1.0 + j0 |
| cos_in | input | 16 | Step-angle cosine, signed Q2.14 |
| sin_in | input | 16 | Step-angle sine, signed Q2.14 |
| out_i | output | 16 | In-phase sample, signed Q2.14 |
| out_q | output | 16 | Quadrature sample, signed Q2.14 |
| out_valid | output | 1 | High for one cycle after each enabled step |

## Verification
Every step is compared bit for bit against an arithmetic model of the rounding rule. A design that truncates, or that rounds ties downward, drifts off the expected words within a few steps. Tunings near zero and near half the sample rate check that amplitude and phase advance stay correct where the coefficient magnitude deviates most from one. A design with a wrong gain constant would settle at the wrong power. A swapped cross term would rotate the wrong way and fail the phase check. Idle cycles with garbage coefficients, and a start pulse that coincides with enable, expose designs that latch coefficients or step at the wrong time. Feeding coefficients of about 2.0 forces the power word into saturation. A design that wraps instead of clamping would produce a positive gain and a wrong sign on the first output.

// File: rtl/qosc_pkg.sv
package qosc_pkg;

    localparam int QW = 16;            // sample word width
    localparam int QF = 14;            // fractional bits
    localparam int PW = 2 * QW + 2;    // wide accumulator width

    typedef logic signed [QW-1:0] smp_t;
    typedef logic signed [PW-1:0] acc_t;

    typedef struct packed {
        smp_t re;
        smp_t im;
    } cplx_t;

    localparam smp_t UNITY     = smp_t'(1 << QF);
    localparam smp_t GAIN_BIAS = smp_t'(3 << (QF - 1));
    localparam smp_t SMP_MAX   = smp_t'((1 << (QW - 1)) - 1);
    localparam smp_t SMP_MIN   = smp_t'(-(1 << (QW - 1)));
    localparam smp_t GAIN_MIN  = smp_t'(int'(GAIN_BIAS) - int'(SMP_MAX));

    localparam cplx_t SEED = '{re: UNITY, im: smp_t'(0)};

    function automatic acc_t widen(input smp_t x);
        return acc_t'(x);
    endfunction

    // round half toward +inf from the product scale, then clamp
    function automatic smp_t rnd_sat(input acc_t x);
        acc_t t;
        t = (x + (acc_t'(1) <<< (QF - 1))) >>> QF;
        if (t > widen(SMP_MAX))
            return SMP_MAX;
        else if (t < widen(SMP_MIN))
            return SMP_MIN;
        else
            return smp_t'(t[QW-1:0]);
    endfunction

    function automatic acc_t mac2(input smp_t a, input smp_t b,
                                  input smp_t c, input smp_t d,
                                  input logic subtract);
        acc_t p0, p1;
        p0 = widen(a) * widen(b);
        p1 = widen(c) * widen(d);
        return subtract ? (p0 - p1) : (p0 + p1);
    endfunction

endpackage

// File: rtl/qosc_rotate.sv
module qosc_rotate
    import qosc_pkg::*;
(
    input  cplx_t prev,
    input  smp_t  cos_c,
    input  smp_t  sin_c,
    output cplx_t rot
);

    always_comb begin
        rot.re = rnd_sat(mac2(prev.re, cos_c, prev.im, sin_c, 1'b1));
        rot.im = rnd_sat(mac2(prev.im, cos_c, prev.re, sin_c, 1'b0));
    end

endmodule

// File: rtl/qosc_agc.sv
module qosc_agc
    import qosc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  cplx_t rot,
    output smp_t  power,
    output smp_t  gain
);

    acc_t gain_wide;

    always_comb begin
        power     = rnd_sat(mac2(rot.re, rot.re, rot.im, rot.im, 1'b0));
        gain_wide = widen(GAIN_BIAS) - widen(power);
        gain      = smp_t'(gain_wide[QW-1:0]);
    end

    // R8: power is a sum of squares and can only clamp high
    a_r8_power_nonneg: assert property (@(posedge clk) disable iff (rst)
        power >= smp_t'(0));

    // R6: gain lies between 1.5 and its value at clamped power
    a_r6_gain_range: assert property (@(posedge clk) disable iff (rst)
        (gain <= GAIN_BIAS) && (gain >= GAIN_MIN));

endmodule

// File: rtl/qosc_scale.sv
module qosc_scale
    import qosc_pkg::*;
#(
    parameter int LANES = 2
) (
    input  smp_t  gain,
    input  cplx_t rot,
    output cplx_t scaled
);

    smp_t lane_in  [LANES];
    smp_t lane_out [LANES];

    assign lane_in[0] = rot.re;
    assign lane_in[1] = rot.im;

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign lane_out[k] = rnd_sat(widen(gain) * widen(lane_in[k]));
    end

    assign scaled.re = lane_out[0];
    assign scaled.im = lane_out[1];

endmodule

// File: rtl/quad_osc_agc.sv
module quad_osc_agc
    import qosc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              start,
    input  logic [QW-1:0]     cos_in,
    input  logic [QW-1:0]     sin_in,
    output logic [QW-1:0]     out_i,
    output logic [QW-1:0]     out_q,
    output logic              out_valid
);

    cplx_t state_q;
    cplx_t rot_w;
    cplx_t next_w;
    smp_t  power_w;
    smp_t  gain_w;
    logic  vld_q;

    qosc_rotate u_rotate (
        .prev  (state_q),
        .cos_c (smp_t'(cos_in)),
        .sin_c (smp_t'(sin_in)),
        .rot   (rot_w)
    );

    qosc_agc u_agc (
        .clk   (clk),
        .rst   (rst),
        .rot   (rot_w),
        .power (power_w),
        .gain  (gain_w)
    );

    qosc_scale #(.LANES(2)) u_scale (
        .gain   (gain_w),
        .rot    (rot_w),
        .scaled (next_w)
    );

    always_ff @(posedge clk) begin
        if (rst || start) begin
            state_q <= SEED;
            vld_q   <= 1'b0;
        end else if (en) begin
            state_q <= next_w;
            vld_q   <= 1'b1;
        end else begin
            vld_q   <= 1'b0;
        end
    end

    assign out_i     = state_q.re;
    assign out_q     = state_q.im;
    assign out_valid = vld_q;

    // R1: reset forces the seed and no valid
    a_r1_reset_seed: assert property (@(posedge clk)
        rst |=> (out_i == UNITY && out_q == '0 && !out_valid));

    // R2: start reloads the seed even when enable is high
    a_r2_start_reload: assert property (@(posedge clk) disable iff (rst)
        start |=> (out_i == UNITY && out_q == '0 && !out_valid));

    // R3: idle edges hold the sample and drop valid
    a_r3_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!en && !start) |=> (!out_valid && $stable(out_i) && $stable(out_q)));

    // R4: each enabled step is flagged on the following cycle
    a_r4_valid_after_step: assert property (@(posedge clk) disable iff (rst)
        (en && !start) |=> out_valid);

endmodule

// File: tb/tb_quad_osc_agc.sv
module tb_quad_osc_agc;

    localparam int CLK_PERIOD = 10;
    localparam real PI = 3.14159265358979;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en = 1'b0;
    logic        start = 1'b0;
    logic [15:0] cos_in = '0;
    logic [15:0] sin_in = '0;
    logic [15:0] out_i;
    logic [15:0] out_q;
    logic        out_valid;

    int n_checks = 0;
    int n_fail = 0;
    longint mi, mq;     // model state
    bit done = 0;

    quad_osc_agc dut (
        .clk(clk), .rst(rst), .en(en), .start(start),
        .cos_in(cos_in), .sin_in(sin_in),
        .out_i(out_i), .out_q(out_q), .out_valid(out_valid)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic longint rs(longint x);
        longint t;
        t = (x + 64'sd8192) >>> 14;
        if (t > 32767) t = 32767;
        if (t < -32768) t = -32768;
        return t;
    endfunction

    function automatic longint sx(logic [15:0] v);
        return longint'($signed(v));
    endfunction

    task automatic model_step(longint c, longint s);
        longint ri, rq, p, g;
        ri = rs(mi * c - mq * s);
        rq = rs(mq * c + mi * s);
        p  = rs(ri * ri + rq * rq);
        g  = 24576 - p;
        mi = rs(g * ri);
        mq = rs(g * rq);
    endtask

    task automatic chk(bit ok, string tag, longint act, longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic report;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    endtask

    function automatic int coef_c(real frac);
        return $rtoi($floor(16384.0 * $cos(2.0 * PI * frac) + 0.5));
    endfunction

    function automatic int coef_s(real frac);
        return $rtoi($floor(16384.0 * $sin(2.0 * PI * frac) + 0.5));
    endfunction

    // one enabled step; leaves time at the negedge after the edge
    task automatic step(int c, int s);
        cos_in = 16'(c);
        sin_in = 16'(s);
        en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        model_step(longint'(c), longint'(s));
    endtask

    task automatic restart;
        start = 1'b1;
        en = 1'b0;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        mi = 16384;
        mq = 0;
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk(sx(out_i) == 16384, "R1 reset out_i", sx(out_i), 16384);
        chk(sx(out_q) == 0, "R1 reset out_q", sx(out_q), 0);
        chk(out_valid == 1'b0, "R1 reset valid", out_valid, 0);
        rst = 1'b0;
        mi = 16384;
        mq = 0;
    endtask

    task automatic t_first_step;
        int c, s;
        longint ri, rq, p, g;
        c = coef_c(0.05);
        s = coef_s(0.05);
        ri = longint'(c);
        rq = longint'(s);
        p = rs(ri * ri + rq * rq);
        g = 24576 - p;
        step(c, s);
        chk(sx(out_i) == rs(g * ri), "R5 R6 first step i", sx(out_i), rs(g * ri));
        chk(sx(out_q) == rs(g * rq), "R5 R6 first step q", sx(out_q), rs(g * rq));
        chk(out_valid == 1'b1, "R4 valid after step", out_valid, 1);
    endtask

    task automatic t_bitexact(real frac, int n, string tag);
        int c, s, bad;
        c = coef_c(frac);
        s = coef_s(frac);
        bad = 0;
        restart();
        for (int k = 0; k < n; k++) begin
            step(c, s);
            if (sx(out_i) != mi || sx(out_q) != mq) bad++;
        end
        chk(bad == 0, {tag, " R7 bit-exact mismatching steps"}, bad, 0);
        chk(sx(out_i) == mi && sx(out_q) == mq, {tag, " R5 R7 final i"}, sx(out_i), mi);
    endtask

    task automatic t_hold;
        longint hi, hq;
        int bad;
        bad = 0;
        hi = sx(out_i);
        hq = sx(out_q);
        en = 1'b0;
        for (int k = 0; k < 6; k++) begin
            cos_in = 16'(k * 5003 + 1234);
            sin_in = 16'(k * 7919 - 30000);
            @(posedge clk);
            @(negedge clk);
            if (sx(out_i) != hi || sx(out_q) != hq || out_valid) bad++;
        end
        chk(bad == 0, "R3 idle hold bad cycles", bad, 0);
        step(coef_c(0.05), coef_s(0.05));
        chk(sx(out_i) == mi && sx(out_q) == mq, "R3 idle coefs ignored", sx(out_i), mi);
        chk(out_valid == 1'b1, "R4 valid on resume", out_valid, 1);
        en = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk(out_valid == 1'b0, "R4 valid one cycle only", out_valid, 0);
    endtask

    task automatic t_start;
        step(coef_c(0.1), coef_s(0.1));
        start = 1'b1;
        en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        en = 1'b0;
        chk(sx(out_i) == 16384, "R2 start out_i", sx(out_i), 16384);
        chk(sx(out_q) == 0, "R2 start out_q", sx(out_q), 0);
        chk(out_valid == 1'b0, "R2 start valid", out_valid, 0);
        mi = 16384;
        mq = 0;
    endtask

    task automatic t_power_sat;
        longint g, e;
        restart();
        step(32767, 32767);
        g = 24576 - 32767;
        e = rs(g * 32767);
        chk(sx(out_i) == e, "R8 clamped power i", sx(out_i), e);
        chk(sx(out_q) == e, "R8 clamped power q", sx(out_q), e);
        chk(sx(out_i) < 0, "R8 negative gain sign", sx(out_i), e);
    endtask

    // power and phase checks after settling
    task automatic t_stable(real frac, int n, string tag);
        int c, s, pbad, abad, bad;
        longint pi_, pq_;
        real pw, meas, want, d;
        c = coef_c(frac);
        s = coef_s(frac);
        want = $atan2(real'(s), real'(c));
        pbad = 0;
        abad = 0;
        bad = 0;
        restart();
        for (int k = 0; k < n; k++) begin
            pi_ = sx(out_i);
            pq_ = sx(out_q);
            step(c, s);
            if (sx(out_i) != mi || sx(out_q) != mq) bad++;
            if (k >= 200) begin
                pw = real'(sx(out_i) * sx(out_i) + sx(out_q) * sx(out_q)) / 16384.0;
                if (pw > 8292.0 || pw < 8092.0) pbad++;
                meas = $atan2(real'(pi_ * sx(out_q) - pq_ * sx(out_i)),
                              real'(pi_ * sx(out_i) + pq_ * sx(out_q)));
                d = meas - want;
                if (d > PI) d = d - 2.0 * PI;
                if (d < -PI) d = d + 2.0 * PI;
                if (d > 0.003 || d < -0.003) abad++;
            end
        end
        chk(pbad == 0, {tag, " R9 power out of band"}, pbad, 0);
        chk(abad == 0, {tag, " R10 phase step off"}, abad, 0);
        chk(bad == 0, {tag, " R7 bit-exact run"}, bad, 0);
    endtask

    task automatic t_retune;
        int c1, s1, c2, s2, pbad;
        real pw;
        c1 = coef_c(0.02);
        s1 = coef_s(0.02);
        c2 = coef_c(0.31);
        s2 = coef_s(0.31);
        pbad = 0;
        restart();
        for (int k = 0; k < 400; k++) step(c1, s1);
        step(c2, s2);
        chk(sx(out_i) == mi && sx(out_q) == mq, "R11 new coefs same step", sx(out_i), mi);
        for (int k = 0; k < 600; k++) begin
            step(c2, s2);
            if (k >= 200) begin
                pw = real'(sx(out_i) * sx(out_i) + sx(out_q) * sx(out_q)) / 16384.0;
                if (pw > 8292.0 || pw < 8092.0) pbad++;
            end
        end
        chk(pbad == 0, "R11 power after retune", pbad, 0);
        en = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL R4 watchdog actual=hung expected=finished");
            report();
        end
    end

    initial begin
        @(posedge clk);
        t_reset();
        t_first_step();
        t_hold();
        t_start();
        t_power_sat();
        t_bitexact(0.25, 50, "quarter");
        t_bitexact(0.125, 80, "eighth");
        t_stable(0.01, 4200, "slow");
        t_stable(0.001, 1500, "near-dc");
        t_stable(0.49, 1500, "near-nyquist");
        t_retune();
        done = 1;
        report();
    end

endmodule